// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block turns one 128-bit plaintext into its 128-bit AES-128 ciphertext under a 128-bit key. It spends one clock cycle per cipher round. The round key for each round is derived in the same cycle from the previous one, so no table of expanded keys is ever held. A caller waits for `ready_o`, presents key and plaintext with a one-cycle `start_i`, and collects the result on `ct_o` when `done_o` pulses.

The whitening step, in which the plaintext is XORed with the raw key, happens on the clock edge that accepts the request. Rounds one to ten follow on the next ten edges. The tenth round uses a separate path that leaves out the column mixing. Each operation covers one block only, in ECB fashion. Any chaining or authentication mode is built outside the block.

Top module: `aes128_iter_core`

## Requirements
- R1: After reset, `ready_o` is 1 and `done_o` is 0.
- R2: A clock edge that sees `start_i` = 1 while `ready_o` = 1 captures `key_i` and `pt_i`, and `ready_o` is 0 in the following cycle.
- R3: `done_o` goes high on the tenth rising edge after the accepting edge and stays high for exactly one cycle. `ready_o` stays 0 from the accepting edge until that same edge, and `ready_o` is 1 while `done_o` is 1.
- R4: While `done_o` is 1, `ct_o` equals the AES-128 encryption of the captured plaintext under the captured key. Byte 0 of every 128-bit value sits in bits [127:120]. Each 32-bit group, taken from the top, is one state column, with its top byte in row 0.
- R5: The cipher applies key whitening with round key 0, nine full rounds, and a tenth round without MixColumns. Round keys 1..10 use the constants 01,02,04,08,10,20,40,80,1B,36 (hex) in that order, so the last round runs with constant 36.
- R6: A `start_i` pulse while `ready_o` is 0 is ignored. The running operation finishes on time with the result of the first request.
- R7: Once `done_o` has pulsed, `ct_o` keeps its value, and `done_o` stays 0, for as long as no new start is accepted.
- R8: A start presented in the cycle where `done_o` is 1 is accepted. The new block then completes with the correct ciphertext and the same latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to encrypt; taken only while ready_o is 1 |
| key_i | input | 128 | Cipher key, sampled on the accepting edge |
| pt_i | input | 128 | Plaintext block, sampled on the accepting edge |
| ready_o | output | 1 | Block is idle and able to accept a request |
| done_o | output | 1 | One-cycle pulse marking a valid ct_o |
| ct_o | output | 128 | Ciphertext; valid from the done pulse until the next accepted start |

## Verification
Four published known-answer vectors, including an all-zero key and plaintext, pin down the round-constant sequence, the byte and column order, and the special last round. A wrong constant, a transposed state, or MixColumns left in round ten each corrupt every ciphertext bit pattern. The latency is counted edge by edge, so an off-by-one in the round counter shows up as a done pulse one cycle early or late. A second start injected mid-operation must leave both the result and the timing untouched; a design that re-latched would emit the wrong ciphertext. A start issued in the done cycle tests the hand-over: a design that blocked it would keep `ready_o` high, and one that corrupted the old result would fail its check.

// File: rtl/aes128_pkg.sv
package aes128_pkg;

  localparam int BLK_W     = 128;
  localparam int BYTE_W    = 8;
  localparam int N_BYTES   = BLK_W / BYTE_W;
  localparam int N_COLS    = 4;
  localparam int N_ROUNDS  = 10;
  localparam int RND_W     = $clog2(N_ROUNDS + 1);
  localparam logic [7:0] RCON_FIRST = 8'h01;
  localparam logic [7:0] RCON_LAST  = 8'h36;

  // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_dbl(p);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  // Forward S-box: multiplicative inverse (x^254) followed by the affine map
  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] pw;
    inv = 8'h01;
    pw  = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) inv = gf_mul(inv, pw);
      pw = gf_mul(pw, pw);
    end
    if (x == 8'h00) inv = 8'h00;
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [31:0] mix_column(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3,
            gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3)};
  endfunction

endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox
  import aes128_pkg::*;
(
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);

  assign y_o = sub_byte(a_i);

endmodule

// File: rtl/aes128_round.sv
module aes128_round
  import aes128_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             final_i,
  output logic [BLK_W-1:0] state_o
);

  logic [7:0] sub_b [N_BYTES];
  logic [7:0] shf_b [N_BYTES];

  for (genvar k = 0; k < N_BYTES; k++) begin : g_sub
    aes128_sbox u_sbox (
      .a_i (state_i[BLK_W-1-BYTE_W*k -: BYTE_W]),
      .y_o (sub_b[k])
    );
  end

  // Byte index k = 4*column + row; row r rotates left by r columns
  always_comb begin
    for (int c = 0; c < N_COLS; c++) begin
      for (int r = 0; r < 4; r++) begin
        shf_b[c*4+r] = sub_b[((c + r) % N_COLS)*4 + r];
      end
    end
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [31:0] col_w;
    logic [31:0] mixed_w;
    assign col_w   = {shf_b[c*4], shf_b[c*4+1], shf_b[c*4+2], shf_b[c*4+3]};
    assign mixed_w = final_i ? col_w : mix_column(col_w);
    assign state_o[BLK_W-1-32*c -: 32] = mixed_w ^ rkey_i[BLK_W-1-32*c -: 32];
  end

endmodule

// File: rtl/aes128_keygen.sv
module aes128_keygen
  import aes128_pkg::*;
(
  input  logic [BLK_W-1:0] key_i,
  input  logic [7:0]       rcon_i,
  output logic [BLK_W-1:0] key_o
);

  logic [31:0] w0, w1, w2, w3;
  logic [31:0] rot_w, sub_w, tmp_w;
  logic [31:0] n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = key_i;
  assign rot_w = {w3[23:0], w3[31:24]};

  for (genvar b = 0; b < 4; b++) begin : g_ksub
    aes128_sbox u_sbox (
      .a_i (rot_w[31-8*b -: 8]),
      .y_o (sub_w[31-8*b -: 8])
    );
  end

  assign tmp_w = sub_w ^ {rcon_i, 24'h000000};
  assign n0 = w0 ^ tmp_w;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign key_o = {n0, n1, n2, n3};

endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
  import aes128_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [127:0]   key_i,
  input  logic [127:0]   pt_i,
  output logic           ready_o,
  output logic           done_o,
  output logic [127:0]   ct_o
);

  logic [BLK_W-1:0] state_q;
  logic [BLK_W-1:0] rkey_q;
  logic [7:0]       rcon_q;
  logic [RND_W-1:0] rnd_q;
  logic             busy_q;
  logic             done_q;

  logic [BLK_W-1:0] key_next_w;
  logic [BLK_W-1:0] round_out_w;
  logic             accept_w;
  logic             last_round_w;

  assign accept_w     = start_i & ~busy_q;
  assign last_round_w = busy_q & (rnd_q == RND_W'(N_ROUNDS));

  aes128_keygen u_keygen (
    .key_i  (rkey_q),
    .rcon_i (rcon_q),
    .key_o  (key_next_w)
  );

  aes128_round u_round (
    .state_i (state_q),
    .rkey_i  (key_next_w),
    .final_i (last_round_w),
    .state_o (round_out_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      rkey_q  <= '0;
      rcon_q  <= RCON_FIRST;
      rnd_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        state_q <= pt_i ^ key_i;
        rkey_q  <= key_i;
        rcon_q  <= RCON_FIRST;
        rnd_q   <= RND_W'(1);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= round_out_w;
        rkey_q  <= key_next_w;
        rcon_q  <= gf_dbl(rcon_q);
        rnd_q   <= rnd_q + RND_W'(1);
        if (last_round_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ready_o = ~busy_q;
  assign done_o  = done_q;
  assign ct_o    = state_q;

endmodule

// File: rtl/aes128_iter_checker.sv
module aes128_iter_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         ready_o,
  input logic         done_o,
  input logic [127:0] ct_o,
  input logic         last_round,
  input logic [7:0]   rcon
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ready_o && !done_o));

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> !ready_o);

  a_r3_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ready_o && $past(!ready_o)));

  a_r5_last_rcon: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |-> (rcon == 8'h36));

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |=> ($stable(ct_o) && !done_o));

endmodule

bind aes128_iter_core aes128_iter_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .ct_o       (ct_o),
  .last_round (last_round_w),
  .rcon       (rcon_q)
);

// File: tb/test_aes128_iter_core.sv
`timescale 1ns/1ps
module test_aes128_iter_core;

  localparam int PERIOD = 8;
  localparam int LAT    = 10;

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] P3 = 128'h6bc1bee22e409f96e93d7e117393172a;
  localparam logic [127:0] C3 = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
  localparam logic [127:0] C0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] pt_i = '0;
  logic         ready_o;
  logic         done_o;
  logic [127:0] ct_o;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  aes128_iter_core i_aes128_iter_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .key_i   (key_i),
    .pt_i    (pt_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .ct_o    (ct_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive a request before an edge, return 2 ns after the accepting edge
  task automatic launch(input logic [127:0] k, input logic [127:0] p);
    @(negedge clk);
    start_i = 1'b1;
    key_i   = k;
    pt_i    = p;
    @(posedge clk);
    #2;
    start_i = 1'b0;
    check(ready_o == 1'b0, "R2 ready low after accept", 128'(ready_o), 128'd0);
  endtask

  // Counts edges until done; returns 2 ns after the done edge
  task automatic await_done(input logic [127:0] exp_ct, input int exp_lat, input string tag);
    int n = 0;
    bit ready_ok = 1'b1;
    while (!done_o && n < 3*LAT) begin
      @(posedge clk);
      #2;
      n++;
      if (!done_o && ready_o) ready_ok = 1'b0;
    end
    check(ready_ok, {"R3 ready stays low while busy ", tag}, 128'(ready_ok), 128'd1);
    check(n == exp_lat, {"R3 latency ", tag}, 128'(n), 128'(exp_lat));
    check(ready_o == 1'b1, {"R3 ready with done ", tag}, 128'(ready_o), 128'd1);
    check(ct_o == exp_ct, {"R4 R5 ciphertext ", tag}, ct_o, exp_ct);
  endtask

  task automatic expect_pulse_end(input string tag);
    @(posedge clk);
    #2;
    check(done_o == 1'b0, {"R3 done one cycle ", tag}, 128'(done_o), 128'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(ready_o == 1'b1, "R1 ready in reset", 128'(ready_o), 128'd1);
    check(done_o == 1'b0, "R1 done in reset", 128'(done_o), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(ready_o == 1'b1 && done_o == 1'b0, "R1 idle after reset",
          128'({ready_o, done_o}), 128'b10);
  endtask

  task automatic t_known_answers();
    launch(K1, P1); await_done(C1, LAT, "kat1"); expect_pulse_end("kat1");
    launch(K2, P2); await_done(C2, LAT, "kat2"); expect_pulse_end("kat2");
    launch('0, '0); await_done(C0, LAT, "zero"); expect_pulse_end("zero");
    launch(K2, P3); await_done(C3, LAT, "ecb"); expect_pulse_end("ecb");
  endtask

  // R6: second start while busy must be ignored
  task automatic t_start_while_busy();
    launch(K1, P1);
    repeat (3) @(posedge clk);
    #2;
    check(ready_o == 1'b0, "R6 busy before stray start", 128'(ready_o), 128'd0);
    start_i = 1'b1;
    key_i   = K2;
    pt_i    = P2;
    @(posedge clk);
    #2;
    start_i = 1'b0;
    await_done(C1, LAT - 4, "R6 stray start");
    expect_pulse_end("R6");
  endtask

  // R7: output and done hold while idle
  task automatic t_hold();
    logic [127:0] snap;
    bit stable_ok = 1'b1;
    snap = ct_o;
    key_i = ~key_i;
    pt_i  = ~pt_i;
    repeat (6) begin
      @(posedge clk);
      #2;
      if (ct_o !== snap || done_o !== 1'b0) stable_ok = 1'b0;
    end
    check(stable_ok, "R7 ct held while idle", ct_o, snap);
    check(ct_o == C1, "R7 held value", ct_o, C1);
  endtask

  // R8: start in the done cycle
  task automatic t_back_to_back();
    launch(K2, P2);
    await_done(C2, LAT, "R8 first");
    start_i = 1'b1;
    key_i   = K1;
    pt_i    = P1;
    @(posedge clk);
    #2;
    start_i = 1'b0;
    check(ready_o == 1'b0, "R8 accepted in done cycle", 128'(ready_o), 128'd0);
    check(done_o == 1'b0, "R8 done cleared", 128'(done_o), 128'd0);
    await_done(C1, LAT, "R8 second");
    expect_pulse_end("R8");
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_known_answers();
    t_start_while_busy();
    t_hold();
    t_back_to_back();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule